// File: doc/BRIEF.md
# Triggered Capture Acquisition Controller

This block decides which incoming sample frames are written into a sample memory, and at which address. A single-cycle strobe marks each frame. One of three modes is selected while the block is enabled.

- **Continuous:** after a trigger, every frame is stored until the enable is cleared.
- **Segmented capture:** each trigger stores a fixed number of frames, and successive captures stack one after another until the programmed buffer is full.
- **Armed pre-trigger:** after an arm pulse the memory is filled as a ring. A trigger then fixes the point from which a set number of further frames are kept, after which the block stops by itself.

The trigger comes either from a software pulse or from an asynchronous external line. The external line is synchronised and edge-detected. In either case the trigger waits, pending, for the next frame strobe. That next frame is the first one stored.

The controller also produces an interrupt pulse after every programmed number of stored frames. It reports the ring position where a pre-trigger capture was triggered, and it flags triggers that it had to ignore.

Top module: `acq_capture_ctrl`

## Requirements
- R1: While the enable is low, and after reset, wr_en, done, irq and overrun are 0 and wr_addr is 0. Dropping the enable returns the block to this state from any mode.
- R2: Mode 0 (continuous): starting with the first strobe after a trigger, every strobe writes. The address starts at 0 and increments, wrapping to 0 after buf_len-1. This continues until the enable is cleared.
- R3: Mode 1 (segmented capture): each trigger causes exactly acq_count strobes to be written at consecutive addresses. Strobes after that write nothing until the next trigger, and the next capture continues at the following address.
- R4: Mode 1: when a capture ends by writing address buf_len-1, done goes to 1 and stays at 1, and no further strobe writes until the enable is cleared. buf_len is expected to be a whole multiple of acq_count.
- R5: Mode 2 (pre-trigger): strobes and triggers have no effect until an arm pulse. After the arm pulse, every strobe writes, circularly over addresses 0 to buf_len-1.
- R6: Mode 2: a trigger makes the next strobe the first post-trigger frame, and trig_ptr takes that frame's address. Exactly acq_count frames, counting that one, are written. done then rises and writing stops.
- R7: With trig_src=0 only sw_trig pulses trigger. With trig_src=1 only rising edges of ext_trig trigger, after a few cycles of synchronisation. A strobe arriving before the trigger is registered does not write.
- R8: When irq_interval is nonzero, irq pulses high for one cycle immediately after every irq_interval-th write since enable. When irq_interval is 0, irq stays low.
- R9: A trigger is ignored in three cases: during a continuous run, during a segmented capture, or after the post-trigger phase has started or done is set. An ignored trigger sets overrun, which stays at 1 until the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low clears all state |
| mode | input | 2 | 0 continuous, 1 segmented capture, 2 pre-trigger |
| trig_src | input | 1 | 0 software trigger, 1 external trigger |
| sw_trig | input | 1 | Software trigger pulse |
| ext_trig | input | 1 | Asynchronous external trigger level |
| arm | input | 1 | Arm pulse for pre-trigger mode |
| sample_valid | input | 1 | One-cycle frame strobe |
| acq_count | input | CNT_W | Frames per capture / post-trigger frames |
| buf_len | input | ADDR_W+1 | Buffer length in frames |
| irq_interval | input | CNT_W | Writes per interrupt, 0 disables |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | ADDR_W | Memory write address |
| done | output | 1 | Capture complete |
| irq | output | 1 | Periodic interrupt pulse |
| trig_ptr | output | ADDR_W | Address of first post-trigger frame |
| overrun | output | 1 | Sticky ignored-trigger flag |

## Verification
Continuous runs are driven longer than the buffer, so that address wrap is separated from plain counting. Segmented captures use random capture sizes and capture counts whose product is the buffer length. This exposes whether a capture stops at exactly acq_count frames, and whether done comes from the buffer end rather than from any capture end. The pre-trigger test runs a random number of frames first, so that the trigger lands mid-ring and trig_ptr differs from zero. Triggers are also placed mid-capture, after done, before arm, and from the deselected source, to show which triggers are ignored and which set overrun.

// File: rtl/acq_capture_ctrl.sv
module acq_capture_ctrl #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              trig_src,
  input  logic              sw_trig,
  input  logic              ext_trig,
  input  logic              arm,
  input  logic              sample_valid,
  input  logic [CNT_W-1:0]  acq_count,
  input  logic [ADDR_W:0]   buf_len,
  input  logic [CNT_W-1:0]  irq_interval,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done,
  output logic              irq,
  output logic [ADDR_W-1:0] trig_ptr,
  output logic              overrun
);

  localparam logic [1:0] M_CAP = 2'd1;
  localparam logic [1:0] M_PRE = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RUN, S_FILL, S_POST, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  seg, icnt;
  logic              pend;
  logic              s1, s2, s3;

  wire ext_rise = s2 & ~s3;
  wire trig     = trig_src ? ext_rise : sw_trig;
  wire accept   = (st == S_WAIT) | (st == S_FILL);
  wire busy     = (st == S_RUN) | (st == S_POST) | (st == S_DONE);
  wire start    = pend & sample_valid;

  wire [ADDR_W:0]   ptr_p1  = {1'b0, ptr} + 1'b1;
  wire              wrap    = ptr_p1 >= buf_len;
  wire [ADDR_W-1:0] ptr_nx  = wrap ? '0 : ptr_p1[ADDR_W-1:0];
  wire [CNT_W-1:0]  seg_p1  = seg + 1'b1;
  wire              seg_end = seg_p1 >= acq_count;
  wire [CNT_W-1:0]  icnt_p1 = icnt + 1'b1;

  assign wr_en   = sample_valid & (((st == S_WAIT) & pend) | (st == S_RUN) |
                                   (st == S_FILL) | (st == S_POST));
  assign wr_addr = ptr;
  assign done    = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_trig;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      seg      <= '0;
      icnt     <= '0;
      pend     <= 1'b0;
      irq      <= 1'b0;
      overrun  <= 1'b0;
      trig_ptr <= '0;
    end else if (!enable) begin
      st       <= S_IDLE;
      ptr      <= '0;
      seg      <= '0;
      icnt     <= '0;
      pend     <= 1'b0;
      irq      <= 1'b0;
      overrun  <= 1'b0;
      trig_ptr <= '0;
    end else begin
      irq <= 1'b0;
      if (trig & busy) overrun <= 1'b1;
      if (start) pend <= 1'b0;
      if (trig & accept) pend <= 1'b1;

      if (wr_en) begin
        ptr <= ptr_nx;
        if (irq_interval != '0) begin
          if (icnt_p1 >= irq_interval) begin
            icnt <= '0;
            irq  <= 1'b1;
          end else begin
            icnt <= icnt_p1;
          end
        end
      end

      case (st)
        S_IDLE: begin
          if (mode == M_PRE) begin
            if (arm) st <= S_FILL;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (start) begin
            if (mode == M_CAP) begin
              if (seg_end) st <= wrap ? S_DONE : S_WAIT;
              else begin
                seg <= seg_p1;
                st  <= S_RUN;
              end
            end else begin
              st <= S_RUN;
            end
          end
        end
        S_RUN: begin
          if (sample_valid && mode == M_CAP) begin
            if (seg_end) begin
              seg <= '0;
              st  <= wrap ? S_DONE : S_WAIT;
            end else begin
              seg <= seg_p1;
            end
          end
        end
        S_FILL: begin
          if (start) begin
            trig_ptr <= ptr;
            if (seg_end) st <= S_DONE;
            else begin
              seg <= seg_p1;
              st  <= S_POST;
            end
          end
        end
        S_POST: begin
          if (sample_valid) begin
            if (seg_end) st <= S_DONE;
            else seg <= seg_p1;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!wr_en && !done && !irq && !overrun));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < buf_len));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> done);

  // R6
  done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && enable) |=> overrun);

endmodule

// File: tb/tb_acq_capture_ctrl.sv
module tb_acq_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 16;

  logic clk = 0, rst_n = 0, enable = 0, trig_src = 0, sw_trig = 0, ext_trig = 0;
  logic arm = 0, sample_valid = 0;
  logic [1:0] mode = 0;
  logic [CNT_W-1:0] acq_count = 1, irq_interval = 0;
  logic [ADDR_W:0] buf_len = 8;
  logic wr_en, done, irq, overrun;
  logic [ADDR_W-1:0] wr_addr, trig_ptr;

  int checks = 0, errors = 0;
  bit finished = 0;

  acq_capture_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .trig_src(trig_src),
    .sw_trig(sw_trig), .ext_trig(ext_trig), .arm(arm), .sample_valid(sample_valid),
    .acq_count(acq_count), .buf_len(buf_len), .irq_interval(irq_interval),
    .wr_en(wr_en), .wr_addr(wr_addr), .done(done), .irq(irq),
    .trig_ptr(trig_ptr), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ring_addr(int n, int len);
    return n % len;
  endfunction

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(output int we, output int wa);
    @(negedge clk); sample_valid = 1; #1;
    we = wr_en; wa = wr_addr;
    @(negedge clk); sample_valid = 0;
  endtask

  task automatic soft_trig();
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
  endtask

  task automatic hard_trig();
    @(negedge clk); ext_trig = 1;
    repeat (5) @(negedge clk);
    ext_trig = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic restart(logic [1:0] m);
    @(negedge clk); enable = 0;
    @(negedge clk); mode = m; enable = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int we, wa, wn, len, acq, ncap, pre;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(wr_en, 0, "R1 wr_en");
    check(done, 0, "R1 done");
    check(irq, 0, "R1 irq");
    check(overrun, 0, "R1 overrun");
    check(wr_addr, 0, "R1 wr_addr");

    // R2 continuous
    buf_len = 8;
    restart(2'd0);
    for (int i = 0; i < 3; i++) begin
      strobe(we, wa); check(we, 0, "R7 no write before trigger");
    end
    soft_trig();
    for (int i = 0; i < 13; i++) begin
      strobe(we, wa);
      check(we, 1, "R2 continuous write");
      check(wa, ring_addr(i, 8), "R2 continuous addr");
    end
    soft_trig();
    check(overrun, 1, "R9 trigger during continuous run");
    strobe(we, wa); check(wa, ring_addr(13, 8), "R9 ignored trigger keeps addr");
    @(negedge clk); enable = 0;
    strobe(we, wa);
    check(we, 0, "R1 disabled no write");
    check(overrun, 0, "R1 overrun cleared");

    // R3 R4 directed segmented capture
    acq_count = 3; buf_len = 9;
    restart(2'd1);
    soft_trig();
    wn = 0;
    for (int i = 0; i < 3; i++) begin
      strobe(we, wa);
      check(we, 1, "R3 capture write");
      check(wa, wn, "R3 capture addr");
      wn++;
      if (i == 0) begin
        soft_trig();
        check(overrun, 1, "R9 trigger mid capture");
      end
    end
    strobe(we, wa); check(we, 0, "R3 stop after acq_count");
    check(done, 0, "R4 not done early");

    // R3 R4 random segmented captures
    for (int r = 0; r < 6; r++) begin
      acq = 1 + int'($urandom % 5);
      ncap = 1 + int'($urandom % 4);
      len = acq * ncap;
      acq_count = CNT_W'(acq); buf_len = (ADDR_W+1)'(len);
      restart(2'd1);
      wn = 0;
      for (int c = 0; c < ncap; c++) begin
        check(done, 0, "R4 done before last capture");
        soft_trig();
        for (int k = 0; k < acq; k++) begin
          strobe(we, wa);
          check(we, 1, "R3 random capture write");
          check(wa, wn, "R3 random capture addr");
          wn++;
        end
        strobe(we, wa); check(we, 0, "R3 idle between captures");
      end
      check(done, 1, "R4 done at buffer full");
      soft_trig();
      check(overrun, 1, "R9 trigger after done");
      strobe(we, wa); check(we, 0, "R4 no write after done");
      check(done, 1, "R4 done held");
    end

    // R5 R6 pre-trigger
    acq_count = 5; buf_len = 8;
    restart(2'd2);
    for (int i = 0; i < 3; i++) begin
      strobe(we, wa); check(we, 0, "R5 no write before arm");
    end
    soft_trig();
    strobe(we, wa); check(we, 0, "R5 trigger before arm ignored");
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    pre = 9 + int'($urandom % 6);
    for (int i = 0; i < pre; i++) begin
      strobe(we, wa);
      check(we, 1, "R5 ring write");
      check(wa, ring_addr(i, 8), "R5 ring addr");
    end
    soft_trig();
    for (int i = 0; i < 5; i++) begin
      strobe(we, wa);
      check(we, 1, "R6 post write");
      check(wa, ring_addr(pre + i, 8), "R6 post addr");
    end
    check(trig_ptr, ring_addr(pre, 8), "R6 trig_ptr");
    check(done, 1, "R6 done");
    strobe(we, wa); check(we, 0, "R6 stopped");

    // R7 external trigger
    acq_count = 2; buf_len = 4; trig_src = 1;
    restart(2'd1);
    soft_trig();
    strobe(we, wa); check(we, 0, "R7 sw trig ignored when external");
    hard_trig();
    strobe(we, wa); check(we, 1, "R7 external trigger write");
    check(wa, 0, "R7 external trigger addr");
    trig_src = 0;
    hard_trig();
    strobe(we, wa); check(we, 1, "R7 second frame of capture");
    strobe(we, wa); check(we, 0, "R7 ext ignored when software");

    // R8 interrupt
    irq_interval = 4; buf_len = 16;
    restart(2'd0);
    soft_trig();
    for (int i = 1; i <= 12; i++) begin
      strobe(we, wa);
      check(irq, (i % 4 == 0) ? 1 : 0, "R8 irq pulse");
      @(negedge clk);
      check(irq, 0, "R8 irq one cycle");
    end
    irq_interval = 0;
    restart(2'd0);
    soft_trig();
    for (int i = 0; i < 6; i++) begin
      strobe(we, wa); check(irq, 0, "R8 irq disabled");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule